// File: doc/BRIEF.md
# Pipeline Stage Trace Recorder

The block keeps a short history for one pipeline stage, to support locating bugs after silicon has come back. Each cycle in which an instruction passes the stage, the stage raises a valid strobe. The recorder then writes one entry into a circular buffer. The entry holds the instruction's compact tag and a field of auxiliary bits whose width is chosen per stage: a program counter, decode result bits, a residue or an address. No entry carries a timestamp. The order of events comes only from where an entry sits in the buffer.

Recording runs freely and overwrites the oldest entry once the buffer is full. When any early-warning source fires (a residue mismatch, an array parity error, a deadlock or segfault detector), the buffer freezes, so the history leading up to the suspect event is kept. It stays frozen until an explicit re-arm. The contents are read out only through a serial scan path, one bit per scan step, starting with the oldest valid entry. There is no parallel readout.

Top module: `trace_rec`

## Requirements
- R1: The tag is `$clog2(4*MAX_INFLIGHT)` bits wide (8 bits for 64 in flight). A stored entry is `{tag, aux}`: the auxiliary field sits in the low `AUX_W` bits and the tag sits directly above it.
- R2: A valid strobe stores one entry when the recorder is not frozen, scan mode is off and neither warning nor re-arm is present. Entries are read back in the order in which they were stored.
- R3: Once `DEPTH` entries are held, each further store overwrites the oldest one. Readout then starts with the oldest of the last `DEPTH` entries.
- R4: Any bit of the warning input freezes recording. A strobe in the same cycle as the warning is not stored, and neither is any strobe after it.
- R5: A re-arm clears the freeze and empties the buffer. When re-arm and warning arrive in the same cycle, the re-arm wins and recording stays enabled.
- R6: While scan mode is off, the readout cursor returns to the oldest entry and bit 0. While scan mode is on, each scan step shifts out exactly one bit, least significant bit of an entry first, and the output holds between steps.
- R7: After all held entries have been shifted out, the scan output reads 0. An empty buffer reads 0 from the start.
- R8: A valid strobe that arrives while scan mode is on is not stored.
- R9: After reset the buffer is empty and not frozen, and the scan output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | An instruction passes the stage this cycle |
| rec_tag | input | TAG_W | Instruction tag, `$clog2(4*MAX_INFLIGHT)` bits |
| rec_aux | input | max(AUX_W,1) | Stage-specific auxiliary bits |
| warn | input | WARN_W | Early-warning sources; any set bit freezes recording |
| rearm | input | 1 | Clear the freeze and empty the buffer |
| scan_en | input | 1 | Scan mode; when low the readout cursor resets |
| scan_step | input | 1 | Shift one bit while in scan mode |
| scan_dout | output | 1 | Serial scan data |

## Verification
The bench builds the recorder with `DEPTH` = 4, `MAX_INFLIGHT` = 64 (an 8-bit tag), `AUX_W` = 6 and `WARN_W` = 4, so each entry is 14 bits wide. The shallow depth makes it possible to wrap the buffer by storing six entries and to check that readout begins with the third of them. The 14-bit entries keep each serial readout short enough to step through the oldest-first ordering, the zeros after the last held entry and a restart of a partly finished scan. The same setting is used for the corner cases: a strobe arriving together with a warning, during scan mode, or after a re-arm that coincides with a warning.

// File: rtl/trace_rec_pkg.sv
package trace_rec_pkg;

    // Tag width that keeps every in-flight instruction distinguishable.
    function automatic int unsigned tag_width(input int unsigned max_inflight);
        return $clog2(4 * max_inflight);
    endfunction

    // Width of one stored entry for a given auxiliary width.
    function automatic int unsigned entry_width(input int unsigned tag_w,
                                                input int unsigned aux_w);
        return tag_w + aux_w;
    endfunction

    // Ring pointer phase.
    typedef enum logic [0:0] {
        RING_FILLING = 1'b0,
        RING_WRAPPED = 1'b1
    } ring_phase_e;

endpackage

// File: rtl/trace_rec_ctrl.sv
module trace_rec_ctrl #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WARN_W = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [WARN_W-1:0] warn,
    input  logic              rearm,
    input  logic              scan_en,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  oldest,
    output logic [CNT_W-1:0]  count
);
    import trace_rec_pkg::*;

    logic        frozen;
    ring_phase_e phase;

    assign phase  = (count == CNT_W'(DEPTH)) ? RING_WRAPPED : RING_FILLING;
    assign oldest = (phase == RING_WRAPPED) ? wr_ptr : '0;
    assign wr_en  = rec_valid && !frozen && !scan_en && !(|warn) && !rearm;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
            frozen <= 1'b0;
        end else if (rearm) begin
            wr_ptr <= '0;
            count  <= '0;
            frozen <= 1'b0;
        end else begin
            if (|warn)
                frozen <= 1'b1;
            if (wr_en) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                if (phase == RING_FILLING)
                    count <= count + 1'b1;
            end
        end
    end

    // R3: the entry count never exceeds the depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R4: once frozen, only a re-arm releases the freeze
    a_r4_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        frozen && !rearm |=> frozen);

    // R4: a warning leaves the write pointer and the count untouched
    a_r4_no_store_on_warn: assert property (@(posedge clk) disable iff (rst)
        (|warn) && !rearm |=> $stable(wr_ptr) && $stable(count));

    // R5: re-arm empties the buffer and releases the freeze
    a_r5_rearm_clears: assert property (@(posedge clk) disable iff (rst)
        rearm |=> count == '0 && !frozen);

    // R8: scan mode blocks storage
    a_r8_scan_blocks: assert property (@(posedge clk) disable iff (rst)
        scan_en && !rearm |=> $stable(count) && $stable(wr_ptr));

endmodule

// File: rtl/trace_rec_store.sv
module trace_rec_store #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ENTRY_W = 14,
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/trace_rec_scan.sv
module trace_rec_scan #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ENTRY_W = 14,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned BIT_W  = $clog2(ENTRY_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_en,
    input  logic               scan_step,
    input  logic [PTR_W-1:0]   oldest,
    input  logic [CNT_W-1:0]   count,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic               scan_dout
);
    logic [PTR_W-1:0]   cur_ptr;
    logic [PTR_W-1:0]   nxt_ptr;
    logic [ENTRY_W-1:0] shreg;
    logic [BIT_W-1:0]   bit_idx;
    logic [CNT_W-1:0]   sent;
    logic               last_bit;

    assign nxt_ptr  = (cur_ptr == PTR_W'(DEPTH - 1)) ? '0 : cur_ptr + 1'b1;
    assign rd_ptr   = scan_en ? nxt_ptr : oldest;
    assign last_bit = (bit_idx == BIT_W'(ENTRY_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            sent    <= '0;
        end else if (!scan_en) begin
            cur_ptr <= oldest;
            shreg   <= rd_data;
            bit_idx <= '0;
            sent    <= '0;
        end else if (scan_step) begin
            if (last_bit) begin
                cur_ptr <= nxt_ptr;
                shreg   <= rd_data;
                bit_idx <= '0;
                if (sent < count)
                    sent <= sent + 1'b1;
            end else begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign scan_dout = (sent < count) ? shreg[0] : 1'b0;

    // R6: the bit index stays inside one entry
    a_r6_bit_range: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= BIT_W'(ENTRY_W - 1));

    // R6: leaving scan mode returns the cursor to the first bit
    a_r6_cursor_reset: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> bit_idx == '0 && sent == '0);

    // R7: never more entries emitted than are held
    a_r7_sent_bound: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> sent <= count);

endmodule

// File: rtl/trace_rec.sv
module trace_rec #(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned MAX_INFLIGHT = 64,
    parameter int unsigned AUX_W        = 6,
    parameter int unsigned WARN_W       = 4,
    localparam int unsigned TAG_W      = trace_rec_pkg::tag_width(MAX_INFLIGHT),
    localparam int unsigned AUX_PORT_W = (AUX_W > 0) ? AUX_W : 1,
    localparam int unsigned ENTRY_W    = trace_rec_pkg::entry_width(TAG_W, AUX_W),
    localparam int unsigned PTR_W      = $clog2(DEPTH),
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rec_valid,
    input  logic [TAG_W-1:0]      rec_tag,
    input  logic [AUX_PORT_W-1:0] rec_aux,
    input  logic [WARN_W-1:0]     warn,
    input  logic                  rearm,
    input  logic                  scan_en,
    input  logic                  scan_step,
    output logic                  scan_dout
);
    logic               wr_en;
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   oldest;
    logic [CNT_W-1:0]   count;
    logic [PTR_W-1:0]   rd_ptr;
    logic [ENTRY_W-1:0] rd_data;
    logic [ENTRY_W-1:0] wr_data;

    generate
        if (AUX_W > 0) begin : g_with_aux
            assign wr_data = {rec_tag, rec_aux};
        end else begin : g_tag_only
            logic aux_unused;
            assign aux_unused = rec_aux[0];
            assign wr_data    = rec_tag;
        end
    endgenerate

    trace_rec_ctrl #(.DEPTH(DEPTH), .WARN_W(WARN_W)) u_ctrl (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .warn(warn),
        .rearm(rearm), .scan_en(scan_en), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .oldest(oldest), .count(count)
    );

    trace_rec_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    trace_rec_scan #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_scan (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_step(scan_step),
        .oldest(oldest), .count(count), .rd_data(rd_data),
        .rd_ptr(rd_ptr), .scan_dout(scan_dout)
    );

    // R6: without a step, the serial output holds in scan mode
    a_r6_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        scan_en && !scan_step && !rearm && $past(scan_en) |=> $stable(scan_dout));

    // R9: reset leaves the scan output low
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> !scan_dout);

endmodule

// File: tb/trace_rec_test.sv
module trace_rec_test;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned TAG_W = 8;
    localparam int unsigned AUX_W = 6;
    localparam int unsigned EW    = TAG_W + AUX_W;

    // expected entries {tag, aux}; walked by the main loop
    localparam logic [EW-1:0] VEC [0:5] = '{
        {8'hA5, 6'h3C}, {8'h01, 6'h01}, {8'h7E, 6'h2A},
        {8'hC3, 6'h15}, {8'hFF, 6'h00}, {8'h5A, 6'h3F}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rec_valid = 1'b0;
    logic [TAG_W-1:0] rec_tag = '0;
    logic [AUX_W-1:0] rec_aux = '0;
    logic [3:0] warn = '0;
    logic rearm = 1'b0;
    logic scan_en = 1'b0;
    logic scan_step = 1'b0;
    logic scan_dout;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    trace_rec #(.DEPTH(DEPTH), .MAX_INFLIGHT(64), .AUX_W(AUX_W), .WARN_W(4)) uut (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_tag(rec_tag),
        .rec_aux(rec_aux), .warn(warn), .rearm(rearm), .scan_en(scan_en),
        .scan_step(scan_step), .scan_dout(scan_dout)
    );

    task automatic check(input string req, input logic [EW-1:0] act,
                         input logic [EW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic record(input logic [EW-1:0] e);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_tag   = e[EW-1:AUX_W];
        rec_aux   = e[AUX_W-1:0];
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic pulse_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    // shift out n bits, LSB first; scan_en must already be high
    task automatic shift_bits(input int n, output logic [EW-1:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            v[i] = scan_dout;
            scan_step = 1'b1;
            @(negedge clk);
            scan_step = 1'b0;
        end
    endtask

    task automatic scan_begin();
        @(negedge clk);
        scan_en = 1'b1;
    endtask

    task automatic scan_end();
        @(negedge clk);
        scan_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        logic [EW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check("R9 reset dout", {13'b0, scan_dout}, '0);
        // R7: empty buffer scans as zeros
        scan_begin(); shift_bits(EW, v); scan_end();
        check("R7 empty scan", v, '0);

        // R2 / R1: two entries, oldest first, aux in low bits
        record(VEC[0]); record(VEC[1]);
        scan_begin();
        shift_bits(EW, v); check("R1 R2 first entry", v, VEC[0]);
        shift_bits(EW, v); check("R2 second entry", v, VEC[1]);
        shift_bits(EW, v); check("R7 zeros after last", v, '0);
        scan_end();

        // R6: partial scan then restart from oldest
        scan_begin(); shift_bits(5, v); scan_end();
        scan_begin(); shift_bits(EW, v); scan_end();
        check("R6 restart from oldest", v, VEC[0]);

        // R3 / R4: table walk wraps the ring, then freeze
        pulse_rearm();
        for (int k = 0; k < 6; k++) record(VEC[k]);
        @(negedge clk); warn = 4'b0100;
        @(negedge clk); warn = 4'b0000;
        record({8'h33, 6'h33});
        scan_begin();
        for (int k = 2; k < 6; k++) begin
            shift_bits(EW, v);
            check("R3 R4 wrapped entry", v, VEC[k]);
        end
        shift_bits(EW, v); check("R4 post-freeze strobe dropped", v, '0);
        scan_end();

        // R4: strobe together with warning is dropped
        pulse_rearm();
        record(VEC[3]);
        @(negedge clk);
        warn = 4'b0001; rec_valid = 1'b1; rec_tag = 8'h99; rec_aux = 6'h11;
        @(negedge clk);
        warn = '0; rec_valid = 1'b0;
        scan_begin();
        shift_bits(EW, v); check("R4 held entry", v, VEC[3]);
        shift_bits(EW, v); check("R4 same-cycle strobe dropped", v, '0);
        scan_end();

        // R5: re-arm beats simultaneous warning
        @(negedge clk); rearm = 1'b1; warn = 4'b1000;
        @(negedge clk); rearm = 1'b0; warn = '0;
        record(VEC[4]);
        scan_begin();
        shift_bits(EW, v); check("R5 recording after rearm", v, VEC[4]);
        shift_bits(EW, v); check("R5 buffer emptied", v, '0);
        scan_end();

        // R8: strobe during scan mode is not stored
        pulse_rearm();
        scan_begin();
        rec_valid = 1'b1; rec_tag = 8'h44; rec_aux = 6'h22;
        @(negedge clk); rec_valid = 1'b0;
        scan_end();
        scan_begin(); shift_bits(EW, v); scan_end();
        check("R8 strobe in scan ignored", v, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule